// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block gates two groups of clock outputs. One group holds differential processor clocks, each a true and complement pair. The other holds single-ended bus clocks plus one free-running member. Each group has its own internal clock and its own active-low stop request. The stop request is asynchronous, so it first passes through a two-flop synchronizer that runs on the falling edge of that group's clock. Each output also has an enable bit that comes from a register.

Every gating decision is made on a falling edge. The gated output is the AND of the clock and a flop that only changes while the clock is low. A stopped output therefore parks low, the complement of a pair parks high, and a restarted output always begins with a full-width high pulse.

Each group has a two-state controller. PARK is the reset state, and in it all gates are closed. RUN opens each gate whose enable bit is set. The WAKE transition (PARK to RUN) fires when the synchronized request reads "run". The HALT transition (RUN to PARK) fires when the synchronized request reads "stop".

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, and asynchronously from the moment it falls, every gated output is low, every complement output is high, `pci_free` is low, and both status outputs read 1.
- R2: Suppose a stop request changes and is stable before falling edge E0 of its group's clock. The change reaches the gates at falling edge E2, the second falling edge after E0. High pulses up to E2 follow the old setting, and the new setting applies from the next rising edge. This holds for stopping and for restarting, in both groups, so each latency is under 4 clock cycles.
- R3: While the processor group is stopped, every `cpu_t` bit is low and every `cpu_c` bit is high.
- R4: While the bus group is stopped, every `pci_out` bit is low and `pci_free` keeps toggling.
- R5: An enable bit of 0 parks its own output from the first falling edge that samples it. For a processor pair, both members park. An enable bit of 1 lets the output follow its clock while the group runs. Bit i of `cpu_en` controls pair i, and bit i of `pci_en` controls `pci_out[i]`.
- R6: Stopping one group does not change the outputs of the other group.
- R7: A gated output changes level only at an edge of its clock. It is constant during each high phase and low during each low phase. No pulse is shorter than the clock's high phase.
- R8: `cpu_parked` and `pci_parked` read 1 exactly while the matching group is in PARK. They change at the same falling edge as that group's gates.
- R9: `pci_free` follows `pci_clk` from the first falling edge of `pci_clk` after reset is released. It ignores `pci_stop_n` and the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Internal processor clock |
| pci_clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous stop request for the processor group, active low |
| pci_stop_n | input | 1 | Asynchronous stop request for the bus group, active low |
| cpu_en | input | N_CPU | Per-pair enable bits, 1 = enabled |
| pci_en | input | N_PCI | Per-output enable bits, 1 = enabled |
| cpu_t | output | N_CPU | Gated true processor clocks |
| cpu_c | output | N_CPU | Gated complement processor clocks |
| pci_out | output | N_PCI | Gated bus clocks |
| pci_free | output | 1 | Free-running bus clock |
| cpu_parked | output | 1 | Processor group is in PARK |
| pci_parked | output | 1 | Bus group is in PARK |

## Verification
The embedded properties rely on two assumptions about the inputs. First, the enable masks are quasi-static: they never change near a falling edge of their clock. Second, reset is asserted only while the clocks are low. Under those conditions, a sampled output level at a falling edge equals the gate flop set at the previous falling edge. The stimulus follows both rules. It drives stop requests and enable masks one time unit after a rising edge of the relevant clock, and it asserts reset just after a falling edge of the slower clock, when both clocks are low. The stop requests themselves are deliberately moved only in the high phase, so the synchronizer is exercised without relying on metastability behaviour.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
    // Controller state of one clock group
    typedef enum logic [0:0] {
        GRP_PARK = 1'b0,
        GRP_RUN  = 1'b1
    } grp_state_e;
endpackage

// File: rtl/stop_sync.sv
// Falling-edge synchronizer for an asynchronous run request (1 = run).
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_sync
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] stg_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[TOP-1:0], req_async};
        end
    end

    assign req_sync = stg_q[TOP];

    generate
        if (STAGES == 2) begin : g_chk2
            // R2: a rising run request crossed exactly two falling edges
            assert_sync_depth_R2: assert property (@(negedge clk) disable iff (!rst_n)
                $rose(req_sync) |-> $past(req_async, 2));
        end
    endgenerate
endmodule

// File: rtl/stop_fsm.sv
// Two-state controller: PARK <-> RUN, updated on the falling edge.
module stop_fsm
    import clk_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic run_next,
    output logic parked
);
    grp_state_e st_q;
    grp_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GRP_PARK: if (run_req)  st_d = GRP_RUN;   // WAKE
            GRP_RUN:  if (!run_req) st_d = GRP_PARK;  // HALT
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GRP_PARK;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        run_next = (st_d == GRP_RUN);
        parked   = (st_q == GRP_PARK);
    end

    assert_halt_R2: assert property (@(negedge clk) disable iff (!rst_n)
        !run_req |=> parked);
    assert_wake_R2: assert property (@(negedge clk) disable iff (!rst_n)
        run_req |=> !parked);
endmodule

// File: rtl/gate_cell.sv
// One output gate: a flop that changes only in the low phase, ANDed with the clock.
module gate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic run_next,
    input  logic en,
    output logic gclk
);
    logic open_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else begin
            open_q <= run_next & en;
        end
    end

    assign gclk = clk & open_q;

    // R5: a closed gate produces no high pulse in the following cycle
    assert_enable_off_R5: assert property (@(negedge clk) disable iff (!rst_n)
        !(run_next && en) |=> !gclk);
endmodule

// File: rtl/clk_stop_grp.sv
// One clock group: synchronizer, controller, and a gate per output.
module clk_stop_grp #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_n,
    input  logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] gclk,
    output logic             parked
);
    logic run_req;
    logic run_next;

    stop_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (stop_n),
        .req_sync  (run_req)
    );

    stop_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_req  (run_req),
        .run_next (run_next),
        .parked   (parked)
    );

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_gate
            gate_cell gate_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .run_next (run_next),
                .en       (en[i]),
                .gclk     (gclk[i])
            );
        end
    endgenerate

    // R3/R4/R8: a parked group shows no high level on any output
    assert_parked_low_R3: assert property (@(negedge clk) disable iff (!rst_n)
        parked |-> (gclk == '0));
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int N_CPU       = 3,
    parameter int N_PCI       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             cpu_clk,
    input  logic             pci_clk,
    input  logic             rst_n,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic [N_CPU-1:0] cpu_en,
    input  logic [N_PCI-1:0] pci_en,
    output logic [N_CPU-1:0] cpu_t,
    output logic [N_CPU-1:0] cpu_c,
    output logic [N_PCI-1:0] pci_out,
    output logic             pci_free,
    output logic             cpu_parked,
    output logic             pci_parked
);
    logic [N_CPU-1:0] cpu_gclk;
    logic             free_on_q;

    clk_stop_grp #(.WIDTH(N_CPU), .SYNC_STAGES(SYNC_STAGES)) cpu_grp_i (
        .clk    (cpu_clk),
        .rst_n  (rst_n),
        .stop_n (cpu_stop_n),
        .en     (cpu_en),
        .gclk   (cpu_gclk),
        .parked (cpu_parked)
    );

    clk_stop_grp #(.WIDTH(N_PCI), .SYNC_STAGES(SYNC_STAGES)) pci_grp_i (
        .clk    (pci_clk),
        .rst_n  (rst_n),
        .stop_n (pci_stop_n),
        .en     (pci_en),
        .gclk   (pci_out),
        .parked (pci_parked)
    );

    assign cpu_t = cpu_gclk;
    assign cpu_c = ~cpu_gclk;

    // Free-running member: opened once after reset, blind to stop and enables
    always_ff @(negedge pci_clk or negedge rst_n) begin
        if (!rst_n) begin
            free_on_q <= 1'b0;
        end else begin
            free_on_q <= 1'b1;
        end
    end

    assign pci_free = pci_clk & free_on_q;

    assert_cpl_high_R3: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        cpu_parked |-> (cpu_c == '1));
    assert_free_runs_R9: assert property (@(negedge pci_clk) disable iff (!rst_n)
        $past(rst_n) |-> pci_free);
endmodule

// File: tb/clk_stop_gate_tb_top.sv
module clk_stop_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PCI_RATIO  = 3;
    localparam int PCI_PERIOD = CLK_PERIOD * PCI_RATIO;
    localparam int NC = 3;
    localparam int NP = 6;
    localparam int C_ALL = (1 << NC) - 1;
    localparam int P_ALL = (1 << NP) - 1;

    logic          cpu_clk = 1'b0;
    logic          pci_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_stop_n = 1'b1;
    logic          pci_stop_n = 1'b1;
    logic [NC-1:0] cpu_en = '1;
    logic [NP-1:0] pci_en = '1;
    logic [NC-1:0] cpu_t, cpu_c;
    logic [NP-1:0] pci_out;
    logic          pci_free, cpu_parked, pci_parked;

    int total = 0;
    int bad = 0;
    int mon_bad = 0;
    bit run_mon = 1'b0;

    clk_stop_gate #(.N_CPU(NC), .N_PCI(NP)) dut_i (
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .rst_n(rst_n),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .cpu_en(cpu_en), .pci_en(pci_en),
        .cpu_t(cpu_t), .cpu_c(cpu_c), .pci_out(pci_out), .pci_free(pci_free),
        .cpu_parked(cpu_parked), .pci_parked(pci_parked)
    );

    initial forever #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
    initial forever #(PCI_PERIOD/2) pci_clk = ~pci_clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_hi();
        @(posedge cpu_clk); #2;
    endtask

    task automatic pci_hi();
        @(posedge pci_clk); #5;
    endtask

    task automatic check_all_parked(input string req);
        check(req, "cpu_t", 32'(cpu_t), 0);
        check(req, "cpu_c", 32'(cpu_c), C_ALL);
        check(req, "pci_out", 32'(pci_out), 0);
        check(req, "pci_free", 32'(pci_free), 0);
        check(req, "cpu_parked", 32'(cpu_parked), 1);
        check(req, "pci_parked", 32'(pci_parked), 1);
    endtask

    // R7 monitors: constant over each high phase, low over each low phase
    initial forever begin
        logic [NC-1:0] a;
        @(posedge cpu_clk); #1 a = cpu_t;
        #3 if (run_mon && cpu_t !== a) mon_bad++;
    end
    initial forever begin
        @(negedge cpu_clk); #2 if (run_mon && cpu_t !== '0) mon_bad++;
    end
    initial forever begin
        logic [NP:0] a;
        @(posedge pci_clk); #1 a = {pci_free, pci_out};
        #12 if (run_mon && {pci_free, pci_out} !== a) mon_bad++;
    end
    initial forever begin
        @(negedge pci_clk); #2 if (run_mon && {pci_free, pci_out} !== '0) mon_bad++;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) cpu_hi();
        check_all_parked("R1");

        @(negedge pci_clk); #1 rst_n = 1'b1;
        repeat (4) pci_hi();
        check("R9", "pci_free after reset", 32'(pci_free), 1);
        check("R2", "pci_out running", 32'(pci_out), P_ALL);
        cpu_hi();
        check("R2", "cpu_t running", 32'(cpu_t), C_ALL);
        check("R3", "cpu_c running", 32'(cpu_c), 0);
        check("R8", "cpu_parked running", 32'(cpu_parked), 0);
        run_mon = 1'b1;

        // CPU stop: R2, R3, R6, R8
        @(posedge cpu_clk); #1 cpu_stop_n = 1'b0;
        @(negedge cpu_clk); @(negedge cpu_clk);
        cpu_hi();
        check("R2", "cpu_t before E2", 32'(cpu_t), C_ALL);
        check("R8", "cpu_parked before E2", 32'(cpu_parked), 0);
        @(negedge cpu_clk);
        cpu_hi();
        check("R3", "cpu_t stopped", 32'(cpu_t), 0);
        check("R3", "cpu_c stopped", 32'(cpu_c), C_ALL);
        check("R8", "cpu_parked stopped", 32'(cpu_parked), 1);
        pci_hi();
        check("R6", "pci_out during cpu stop", 32'(pci_out), P_ALL);
        check("R6", "pci_parked during cpu stop", 32'(pci_parked), 0);
        // CPU restart
        @(posedge cpu_clk); #1 cpu_stop_n = 1'b1;
        @(negedge cpu_clk); @(negedge cpu_clk);
        cpu_hi();
        check("R2", "cpu_t restart not early", 32'(cpu_t), 0);
        @(negedge cpu_clk);
        cpu_hi();
        check("R2", "cpu_t restarted", 32'(cpu_t), C_ALL);
        check("R8", "cpu_parked restarted", 32'(cpu_parked), 0);

        // PCI stop: R2, R4, R6, R8
        @(posedge pci_clk); #1 pci_stop_n = 1'b0;
        @(negedge pci_clk); @(negedge pci_clk);
        pci_hi();
        check("R2", "pci_out before E2", 32'(pci_out), P_ALL);
        @(negedge pci_clk);
        pci_hi();
        check("R4", "pci_out stopped", 32'(pci_out), 0);
        check("R4", "pci_free during stop", 32'(pci_free), 1);
        check("R8", "pci_parked stopped", 32'(pci_parked), 1);
        cpu_hi();
        check("R6", "cpu_t during pci stop", 32'(cpu_t), C_ALL);
        @(posedge pci_clk); #1 pci_stop_n = 1'b1;
        @(negedge pci_clk); @(negedge pci_clk);
        pci_hi();
        check("R2", "pci_out restart not early", 32'(pci_out), 0);
        @(negedge pci_clk);
        pci_hi();
        check("R2", "pci_out restarted", 32'(pci_out), P_ALL);
        check("R8", "pci_parked restarted", 32'(pci_parked), 0);

        // R5: exhaustive enable sweeps
        for (int m = 0; m <= C_ALL; m++) begin
            @(posedge cpu_clk); #1 cpu_en = NC'(m);
            @(negedge cpu_clk);
            cpu_hi();
            check("R5", "cpu_t mask", 32'(cpu_t), m);
            check("R5", "cpu_c mask", 32'(cpu_c), (~m) & C_ALL);
        end
        for (int m = 0; m <= P_ALL; m++) begin
            @(posedge pci_clk); #1 pci_en = NP'(m);
            @(negedge pci_clk);
            pci_hi();
            check("R5", "pci_out mask", 32'(pci_out), m);
            check("R9", "pci_free mask", 32'(pci_free), 1);
        end

        // R1: asynchronous reset while running
        @(negedge pci_clk); #1 rst_n = 1'b0;
        cpu_hi();
        check_all_parked("R1");
        @(negedge pci_clk); #1 rst_n = 1'b1;
        repeat (4) pci_hi();
        check("R9", "pci_free after second reset", 32'(pci_free), 1);
        check("R2", "pci_out after second reset", 32'(pci_out), P_ALL);

        repeat (4) pci_hi();
        check("R7", "runt/phase violations", 32'(mon_bad), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule